// File: doc/BRIEF.md
# Best-Time Stopwatch Controller

This block is a sprint stopwatch that also remembers the fastest run of the current session. It runs from a 100 Hz clock, so one timer step is 0.01 s. Time is held as four packed BCD digits, the lower two being hundredths, which gives a range of 00.00 to 99.99 s. Three push-button style inputs drive it: `start` begins a run, `stop` ends it, and `cmp_store` asks the block to compare the last run with the session best, keep the smaller one and show the best. An asynchronous `rst` ends the session and sets the session best back to 99.99.

Inside, a seven-state Moore controller with one-hot states sequences three datapath pieces. The first is a BCD run timer with a synchronous clear and a count enable that feeds the carry into the lowest digit. The second is a session-best register whose load value comes either from the constant 99.99 or from the run timer. The third is a strict less-than comparator that checks digits from the most significant one down. The display output is packed BCD that shows either the run timer or the session best. Seven-segment decoding is left to a later stage.

The states are: INIT (S1, load 99.99 into the best register), CLEAR (S2, clear the timer and wait), RUN (S3, count), HALT (S4, show the stopped time), CMP (S5, compare), STORE (S6, copy the timer into the best) and SHOW (S7, show the best). The transitions are: INIT→CLEAR always. CLEAR→RUN on start. RUN→HALT on stop. HALT→CLEAR on start, and HALT→CMP on cmp_store when start is low. CMP→STORE when timer < best, otherwise CMP→SHOW. STORE→SHOW always. SHOW→CLEAR on start. Every other case holds the current state.

Top module: `best_time_watch`

## Requirements
- R1: While `rst` is high the state is INIT and the timer reads 0000. On the first clock edge after release the state moves to CLEAR and the best register holds 9999 (1001_1001_1001_1001).
- R2: `state_oh` always has exactly one bit set. Bit 0 is INIT, then bit 1 CLEAR, bit 2 RUN, bit 3 HALT, bit 4 CMP, bit 5 STORE and bit 6 SHOW.
- R3: Each edge in CLEAR sets the timer to 0000. CLEAR holds until `start` is seen, and then moves to RUN.
- R4: Each edge in RUN adds one to the lowest BCD digit of the timer, with decimal carries into the higher digits. `start` and `cmp_store` have no effect in RUN. `stop` moves the state to HALT.
- R5: When the timer reads 9999 in RUN it keeps that value and does not wrap.
- R6: In HALT the timer value is held. `start` moves the state to CLEAR and wins over `cmp_store`. With only `cmp_store` high the state moves to CMP. With neither high the state stays in HALT.
- R7: From CMP the next state is STORE only when timer < best (strict, by BCD value). Otherwise it is SHOW. STORE copies the timer into the best register and moves to SHOW.
- R8: The best register changes only in INIT and STORE, so it never increases during a session. In SHOW, `start` moves the state to CLEAR and the best value carries into later runs.
- R9: `dp_en` is always 1.
- R10: `disp` shows the timer in INIT, CLEAR, RUN and HALT. It shows the best register in CMP, STORE and SHOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 Hz timing clock |
| rst | input | 1 | Asynchronous session reset, active high |
| start | input | 1 | Begin a new run |
| stop | input | 1 | End the current run |
| cmp_store | input | 1 | Compare the last run with the best and keep the shorter |
| disp | output | 16 | Packed BCD display value, four digits, hundredths in bits 3:0 |
| dp_en | output | 1 | Decimal point enable between digit 2 and digit 1 |
| state_oh | output | 7 | One-hot controller state |

## Verification
The assertions check on every cycle that the state stays one-hot and that each named transition follows its condition. They also check that the timer clears after CLEAR, steps while counting and freezes at 9999, and that the best register never grows except at INIT. Other behaviour only the bench scenarios can show: that the BCD carries produce the right decimal value over a sweep of run lengths, that the compare-and-store path keeps the true session minimum across many runs, including equal times, and that an asynchronous reset in the middle of a run restores 99.99 as the best value.

// File: rtl/bestwatch_pkg.sv
package bestwatch_pkg;

    typedef enum logic [6:0] {
        ST_INIT  = 7'b000_0001,
        ST_CLEAR = 7'b000_0010,
        ST_RUN   = 7'b000_0100,
        ST_HALT  = 7'b000_1000,
        ST_CMP   = 7'b001_0000,
        ST_STORE = 7'b010_0000,
        ST_SHOW  = 7'b100_0000
    } watch_state_t;

    typedef struct packed {
        logic tm_clr;     // synchronous timer clear
        logic tm_en;      // carry into the lowest digit
        logic best_ld;    // load the best register
        logic best_src;   // 0: all nines, 1: timer
        logic disp_sel;   // 0: timer, 1: best
        logic dp;         // decimal point enable
    } watch_ctrl_t;

endpackage

// File: rtl/bcd_run_timer.sv
module bcd_run_timer #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  en,
    output logic [4*DIGITS-1:0]   value,
    output logic                  full
);
    localparam int W = 4 * DIGITS;

    logic [DIGITS-1:0] nines;
    logic [DIGITS:0]   carry;

    assign full     = &nines;
    assign carry[0] = en & ~full;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] dq;
        assign nines[i]      = (dq == 4'd9);
        assign carry[i+1]    = carry[i] & nines[i];
        assign value[4*i +: 4] = dq;

        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                dq <= 4'd0;
            end else if (clr) begin
                dq <= 4'd0;
            end else if (carry[i]) begin
                dq <= nines[i] ? 4'd0 : dq + 4'd1;
            end
        end
    end

    // R3: a clear cycle leaves the timer at zero
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (value == '0));

    // R4: a counting step always changes the value
    a_r4_step_moves: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !full) |=> (value != $past(value)));

    // R5: at all nines the timer holds
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && full) |=> $stable(value));

    logic [W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/bcd_less_than.sv
module bcd_less_than #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] a,
    input  logic [4*DIGITS-1:0] b,
    output logic                lt
);
    // stage s looks at digit DIGITS-1-s, most significant first
    logic [DIGITS:0] decided;
    logic [DIGITS:0] less;

    assign decided[0] = 1'b0;
    assign less[0]    = 1'b0;

    for (genvar s = 0; s < DIGITS; s++) begin : g_cell
        localparam int D = DIGITS - 1 - s;
        logic [3:0] da, db;
        assign da = a[4*D +: 4];
        assign db = b[4*D +: 4];
        assign decided[s+1] = decided[s] | (da != db);
        assign less[s+1]    = decided[s] ? less[s] : (da < db);
    end

    assign lt = less[DIGITS];
endmodule

// File: rtl/best_time_reg.sv
module best_time_reg #(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                src_timer,
    input  logic [4*DIGITS-1:0] timer_val,
    output logic [4*DIGITS-1:0] best
);
    localparam int W = 4 * DIGITS;
    localparam logic [W-1:0] ALL_NINES = {DIGITS{4'h9}};

    logic [W-1:0] load_val;
    assign load_val = src_timer ? timer_val : ALL_NINES;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       best <= '0;
        else if (load) best <= load_val;
    end

    // R8: no load, no change
    a_r8_hold_unless_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(best));
endmodule

// File: rtl/watch_ctrl_fsm.sv
module watch_ctrl_fsm
    import bestwatch_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         stop,
    input  logic         cmp_store,
    input  logic         alt,
    output watch_state_t state,
    output watch_ctrl_t  ctrl
);
    watch_state_t nxt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_INIT;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_INIT:  nxt = ST_CLEAR;
            ST_CLEAR: if (start) nxt = ST_RUN;
            ST_RUN:   if (stop)  nxt = ST_HALT;
            ST_HALT: begin
                if (start)          nxt = ST_CLEAR;
                else if (cmp_store) nxt = ST_CMP;
            end
            ST_CMP:   nxt = alt ? ST_STORE : ST_SHOW;
            ST_STORE: nxt = ST_SHOW;
            ST_SHOW:  if (start) nxt = ST_CLEAR;
            default:  nxt = ST_INIT;
        endcase
    end

    always_comb begin
        ctrl    = '0;
        ctrl.dp = 1'b1;
        unique case (state)
            ST_INIT: begin
                ctrl.best_ld  = 1'b1;
                ctrl.best_src = 1'b0;
            end
            ST_CLEAR: ctrl.tm_clr = 1'b1;
            ST_RUN:   ctrl.tm_en  = 1'b1;
            ST_HALT:  ctrl.disp_sel = 1'b0;
            ST_CMP:   ctrl.disp_sel = 1'b1;
            ST_STORE: begin
                ctrl.best_ld  = 1'b1;
                ctrl.best_src = 1'b1;
                ctrl.disp_sel = 1'b1;
            end
            ST_SHOW:  ctrl.disp_sel = 1'b1;
            default:  ctrl.disp_sel = 1'b0;
        endcase
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    a_r3_wait_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR && !start) |=> (state == ST_CLEAR));

    a_r4_stop_halts: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && stop) |=> (state == ST_HALT));

    a_r6_start_wins: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && start) |=> (state == ST_CLEAR));

    a_r7_store_if_less: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMP && alt) |=> (state == ST_STORE));

    a_r7_skip_if_not_less: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMP && !alt) |=> (state == ST_SHOW));
endmodule

// File: rtl/best_time_watch.sv
module best_time_watch
    import bestwatch_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 stop,
    input  logic                 cmp_store,
    output logic [4*DIGITS-1:0]  disp,
    output logic                 dp_en,
    output logic [6:0]           state_oh
);
    localparam int W = 4 * DIGITS;
    localparam logic [W-1:0] ALL_NINES = {DIGITS{4'h9}};

    watch_state_t state;
    watch_ctrl_t  ctrl;
    logic [W-1:0] timer_q;
    logic [W-1:0] best_q;
    logic         timer_full;
    logic         alt;

    watch_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .cmp_store (cmp_store),
        .alt       (alt),
        .state     (state),
        .ctrl      (ctrl)
    );

    bcd_run_timer #(.DIGITS(DIGITS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctrl.tm_clr),
        .en    (ctrl.tm_en),
        .value (timer_q),
        .full  (timer_full)
    );

    best_time_reg #(.DIGITS(DIGITS)) u_best (
        .clk       (clk),
        .rst       (rst),
        .load      (ctrl.best_ld),
        .src_timer (ctrl.best_src),
        .timer_val (timer_q),
        .best      (best_q)
    );

    bcd_less_than #(.DIGITS(DIGITS)) u_cmp (
        .a  (timer_q),
        .b  (best_q),
        .lt (alt)
    );

    assign disp     = ctrl.disp_sel ? best_q : timer_q;
    assign dp_en    = ctrl.dp;
    assign state_oh = state;

    logic unused_full;
    assign unused_full = timer_full;

    // R1: leaving INIT the best register holds all nines
    a_r1_init_nines: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT) |=> (best_q == ALL_NINES));

    // R8: outside INIT the best value never grows
    a_r8_never_grows: assert property (@(posedge clk) disable iff (rst)
        (state != ST_INIT) |=> (best_q <= $past(best_q)));

    // R7: a store only ever follows a strict win in CMP
    a_r7_store_after_win: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE) |-> (timer_q < best_q));
endmodule

// File: tb/best_time_watch_test.sv
module best_time_watch_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        cmp_store = 1'b0;
    logic [15:0] disp;
    logic        dp_en;
    logic [6:0]  state_oh;

    int n_tests = 0;
    int n_fail  = 0;
    int best_e  = 9999;
    int cycles  = 0;
    bit done    = 1'b0;

    localparam logic [6:0] S_INIT = 7'd1, S_CLEAR = 7'd2, S_RUN = 7'd4,
                           S_HALT = 7'd8, S_CMP = 7'd16, S_STORE = 7'd32,
                           S_SHOW = 7'd64;

    always #2 clk = ~clk;

    best_time_watch uut (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .cmp_store(cmp_store), .disp(disp), .dp_en(dp_en), .state_oh(state_oh)
    );

    function automatic logic [15:0] bcd(int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
    endtask

    // run one dash of n counting edges, starting from CLEAR, HALT or SHOW
    task automatic dash(int n, bit poke, bit css_too);
        int t;
        if (state_oh != S_CLEAR) begin
            start = 1'b1;
            cmp_store = css_too;
            tick();
            cmp_store = 1'b0;
            chk("R6/R8 start to CLEAR", 32'(state_oh), 32'(S_CLEAR));
        end
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R3 run begins", 32'(state_oh), 32'(S_RUN));
        chk("R3 timer cleared", 32'(disp), 32'h0);
        for (int i = 1; i < n; i++) begin
            start     = (poke && i == 2);
            cmp_store = (poke && i == 3);
            tick();
        end
        start = 1'b0;
        cmp_store = 1'b0;
        if (poke) chk("R4 start/css ignored in RUN", 32'(state_oh), 32'(S_RUN));
        stop = 1'b1;
        tick();
        stop = 1'b0;
        t = (n > 9999) ? 9999 : n;
        chk("R4 stop to HALT", 32'(state_oh), 32'(S_HALT));
        chk(n > 9999 ? "R5 saturate" : "R4 BCD count", 32'(disp), 32'(bcd(t)));
        chk("R9 dp", 32'(dp_en), 32'h1);
    endtask

    task automatic compare(int n);
        int t;
        t = (n > 9999) ? 9999 : n;
        cmp_store = 1'b1;
        tick();
        cmp_store = 1'b0;
        chk("R6 css to CMP", 32'(state_oh), 32'(S_CMP));
        chk("R10 CMP shows best", 32'(disp), 32'(bcd(best_e)));
        tick();
        if (t < best_e) begin
            chk("R7 less goes to STORE", 32'(state_oh), 32'(S_STORE));
            tick();
            best_e = t;
        end
        chk("R7 reach SHOW", 32'(state_oh), 32'(S_SHOW));
        chk("R8 SHOW shows best", 32'(disp), 32'(bcd(best_e)));
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            if (cycles > 190000) begin
                n_fail++; n_tests++;
                $display("FAIL watchdog: actual %0d expected below 190000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    always @(posedge clk) if (!done) cycles = cycles;

    initial begin
        @(negedge clk);
        chk("R1 reset state", 32'(state_oh), 32'(S_INIT));
        chk("R1 reset display", 32'(disp), 32'h0);
        chk("R9 dp in reset", 32'(dp_en), 32'h1);
        rst = 1'b0;
        tick();
        chk("R1 to CLEAR", 32'(state_oh), 32'(S_CLEAR));
        for (int i = 0; i < 3; i++) tick();
        chk("R3 wait in CLEAR", 32'(state_oh), 32'(S_CLEAR));
        chk("R2 onehot CLEAR code", 32'($countones(state_oh)), 32'd1);

        // saturating run, equal to initial best: no store
        dash(10010, 1'b0, 1'b0);
        compare(10010);
        chk("R1 best still 9999", 32'(disp), 32'h9999);

        dash(5000, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) tick();
        chk("R6 HALT holds", 32'(state_oh), 32'(S_HALT));
        chk("R10 HALT shows timer", 32'(disp), 32'h5000);
        compare(5000);
        dash(6000, 1'b0, 1'b0);
        compare(6000);
        dash(1234, 1'b1, 1'b0);
        compare(1234);
        // start and css together in HALT: start wins (R6)
        dash(999, 1'b0, 1'b0);
        dash(1000, 1'b0, 1'b1);
        compare(1000);
        dash(999, 1'b0, 1'b0);
        compare(999);

        // sweep of short runs through carries and both compare outcomes
        for (int n = 1; n <= 150; n++) begin
            dash(n, (n >= 4) && (n % 7 == 0), 1'b0);
            compare(n);
        end
        dash(1, 1'b0, 1'b0);
        compare(1);

        // asynchronous reset mid-run restores 99.99
        start = 1'b1;
        tick();
        tick();
        start = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        rst = 1'b1;
        #1;
        chk("R1 async reset state", 32'(state_oh), 32'(S_INIT));
        chk("R1 async reset timer", 32'(disp), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        tick();
        chk("R1 back to CLEAR", 32'(state_oh), 32'(S_CLEAR));
        best_e = 9999;
        dash(7000, 1'b0, 1'b0);
        compare(7000);
        chk("R8 best after reset", 32'(disp), 32'h7000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule